// File: doc/BRIEF.md
# Two-Wire Register Slave with Pointer Stepping

This block is the serial-bus side of a small peripheral. It watches an open-drain clock and data pair, recognises START, repeated START and STOP conditions, and answers to one 7-bit address picked by a 2-bit strap. Behind the bus it holds a pointer and a bank of seven 8-bit registers. Index 0 is a read-only window onto an external event queue. Indices 1 to 6 are writable settings.

After a write address, the first byte sets the pointer. Each later byte is stored at the pointer, and the pointer then steps. A read starts at the stored pointer and steps by the same rule. The stepping rule keeps the pointer on index 0, so the host can drain the event queue by reading repeatedly. It moves 1 to 5 forward by one and wraps 6 back to 0.

Every byte that the bus reads from index 0 produces a one-cycle pop toward the queue. Every accepted write appears on a one-cycle register-write port. An optional watchdog on the clock-low time abandons a hung transfer and frees the data line. The block's outputs are valid-only strobes with no back-pressure, because a slave cannot stall a transfer it does not clock.

Top module: `i2cs_reg_slave`

## Requirements
- R1: The block answers only to the 7-bit address {0111, strap, 0}, which gives 0x38, 0x3A, 0x3C or 0x3E for strap 0 to 3, followed by the R/W bit (0 = write). A transfer to any other address gets no acknowledge, writes nothing and leaves the pointer unchanged.
- R2: The first byte after a matched write address is loaded into the pointer. A STOP that follows it changes only the pointer.
- R3: Each later write byte aimed at index 1 to 6 produces exactly one single-cycle `wr_valid_o` pulse, carrying that index on `wr_addr_o` and the byte on `wr_data_o`. It is then returned by later reads.
- R4: After each data byte, written or read, the pointer steps as follows: 0 stays 0, 1 to 5 go up by one, 6 goes to 0, and values of 7 or above are kept.
- R5: After reset, index 1 to 6 read 0x0A, 0xFF, 0x00, 0xFE, 0x00 and 0x07.
- R6: Read data leaves MSB first. The slave changes the data line only while the clock is low.
- R7: On a read, a master NACK ends the transfer. The data line stays released and no further pop occurs until the next START.
- R8: A repeated START is handled like a START and keeps the pointer.
- R9: Each byte read from index 0 carries the current `evq_data_i` and produces exactly one single-cycle `evq_pop_o` pulse.
- R10: When bit 0 of index 1 is 0 (the reset value) and the clock stays low for more than TIMEOUT_CYCLES during a transfer, the slave releases the data line and ignores the bus until a new START. When bit 0 is 1, the watchdog is off.
- R11: Bytes written to index 0 (read-only) or to an index of 7 or above are acknowledged, but they produce no write pulse.
- R12: The slave acknowledges a matched address and every received byte by pulling the data line low for the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 2 | Address select code (0 ground, 1 supply, 2 data, 3 clock) |
| sda_pull_o | output | 1 | 1 = pull the data line low (open drain) |
| evq_data_i | input | 8 | Current head byte of the event queue, read at index 0 |
| evq_pop_o | output | 1 | One-cycle pulse: the head byte was taken |
| wr_valid_o | output | 1 | One-cycle pulse: a register write is presented |
| wr_addr_o | output | 3 | Index written |
| wr_data_o | output | 8 | Byte written |

## Verification
The bench attacks the pointer rule at its edges. It reads across the wrap from 6 to 0, drains the queue while parked on index 0, and steers into index 7. A design that incremented from 0 would skip queue entries, and one that did not wrap would return zeros. Repeated STARTs placed between the pointer byte and the read catch a design that reset the pointer on restart. Stray addresses catch one that answered or wrote for the wrong strap. A stretched clock-low hold during a driven acknowledge is run once with the watchdog on and once with it off. A missing watchdog keeps the line pulled low, and one that ignored its enable drops a transfer that should survive.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  localparam int unsigned NREG = 7;
  localparam int unsigned DW   = 8;
  localparam logic [3:0]  ADDR_HI = 4'b0111;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } i2cs_state_e;

  function automatic logic [DW-1:0] reg_reset(int unsigned idx);
    case (idx)
      1:       return 8'h0A;
      2:       return 8'hFF;
      3:       return 8'h00;
      4:       return 8'hFE;
      5:       return 8'h00;
      6:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] next_ptr(logic [7:0] p);
    if (p == 8'd0)                 return 8'd0;
    else if (p == 8'(NREG - 1))    return 8'd0;
    else if (p < 8'(NREG - 1))     return p + 8'd1;
    else                           return p;
  endfunction
endpackage

// File: rtl/i2cs_bus_cond.sv
`timescale 1ns/1ps
module i2cs_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_p    <= scl_sync[1];
      sda_p    <= sda_sync[1];
    end
  end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_timeout.sv
`timescale 1ns/1ps
module i2cs_timeout #(
  parameter int unsigned LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic busy,
  input  logic scl_s,
  output logic abort
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;
  logic          counting;

  assign counting = enable & busy & ~scl_s;
  assign abort    = counting && (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!counting)       cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cs_regfile.sv
`timescale 1ns/1ps
module i2cs_regfile
  import i2cs_pkg::*;
#(
  parameter int unsigned N = NREG,
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [7:0]   waddr,
  input  logic [W-1:0] wdata,
  input  logic [7:0]   raddr,
  input  logic [W-1:0] q0_data,
  output logic [W-1:0] rdata,
  output logic         tmo_en
);
  logic [N*W-1:0] flat;

  assign flat[W-1:0] = q0_data;

  for (genvar gi = 1; gi < N; gi++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= reg_reset(gi);
      else if (we && waddr == 8'(gi))      q <= wdata;
    end
    assign flat[gi*W +: W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (raddr == 8'(i)) rdata = flat[i*W +: W];
  end

  assign tmo_en = ~flat[W];
endmodule

// File: rtl/i2cs_reg_slave.sv
`timescale 1ns/1ps
module i2cs_reg_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 20000,
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    strap_i,
  output logic          sda_pull_o,
  input  logic [DW-1:0] evq_data_i,
  output logic          evq_pop_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic abort, tmo_en;
  i2cs_state_e state;
  logic [3:0]    bitcnt;
  logic [DW-1:0] shreg, tx, rd_byte;
  logic [7:0]    ptr;
  logic [6:0]    own_addr;
  logic          rw, mack, sda_pull, wr_evt, ptr_writable;

  i2cs_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .enable(tmo_en),
    .busy(state != ST_IDLE), .scl_s(scl_s), .abort(abort)
  );

  assign own_addr     = {ADDR_HI, strap_i, 1'b0};
  assign ptr_writable = (ptr != 8'd0) && (ptr < 8'(NREG));
  assign wr_evt       = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8) &&
                        ptr_writable && !start_det && !stop_det && !abort;

  i2cs_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_evt), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .q0_data(evq_data_i), .rdata(rd_byte), .tmo_en(tmo_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_pull <= 1'b0; evq_pop_o <= 1'b0;
      wr_valid_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      evq_pop_o  <= 1'b0;
      wr_valid_o <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR; bitcnt <= '0; sda_pull <= 1'b0;
      end else if (stop_det || abort) begin
        state <= ST_IDLE; sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == own_addr) begin
                  rw <= shreg[0]; sda_pull <= 1'b1; state <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr <= shreg; sda_pull <= 1'b1; state <= ST_PTR_ACK;
              end else begin
                if (wr_evt) begin
                  wr_valid_o <= 1'b1; wr_addr_o <= ptr[AW-1:0]; wr_data_o <= shreg;
                end
                ptr <= next_ptr(ptr); sda_pull <= 1'b1; state <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                tx <= {rd_byte[DW-2:0], 1'b0}; sda_pull <= ~rd_byte[DW-1];
                bitcnt <= 4'd1; evq_pop_o <= (ptr == 8'd0);
                ptr <= next_ptr(ptr); state <= ST_RDATA;
              end else begin
                sda_pull <= 1'b0; state <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0; state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0; state <= ST_RACK;
              end else begin
                sda_pull <= ~tx[DW-1]; tx <= {tx[DW-2:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx <= {rd_byte[DW-2:0], 1'b0}; sda_pull <= ~rd_byte[DW-1];
                bitcnt <= 4'd1; evq_pop_o <= (ptr == 8'd0);
                ptr <= next_ptr(ptr); state <= ST_RDATA;
              end else begin
                sda_pull <= 1'b0; state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = sda_pull;
endmodule

// File: rtl/i2cs_reg_slave_chk.sv
`timescale 1ns/1ps
module i2cs_reg_slave_chk
  import i2cs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_pull_o,
  input logic        evq_pop_o,
  input logic        wr_valid_o,
  input logic [2:0]  wr_addr_o,
  input logic        abort,
  input i2cs_state_e state
);
  assert_pop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evq_pop_o |=> !evq_pop_o);
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
  assert_wr_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_addr_o != 3'd0 && wr_addr_o != 3'd7));
  assert_sda_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));
  assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!sda_pull_o && state == ST_IDLE));
  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state == ST_IDLE)) |-> !sda_pull_o);
endmodule

bind i2cs_reg_slave i2cs_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .evq_pop_o(evq_pop_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
  .abort(abort), .state(state)
);

// File: tb/i2cs_reg_slave_tb.sv
`timescale 1ns/1ps
module i2cs_reg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q   = 5;
  localparam int TMO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_pull, evq_pop, wr_valid;
  logic [2:0] wr_addr;
  logic [7:0] wr_data, evq_data;
  logic sda_line;

  int checks = 0, failures = 0;
  int wr_cnt = 0, pop_cnt = 0;
  logic [2:0] last_wa;
  logic [7:0] last_wd;
  logic [7:0] evq_mem [16];
  logic [7:0] exp_reg [7];
  logic [7:0] exp_ptr = 8'd0;
  int exp_pop = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_pull;
  assign evq_data = evq_mem[pop_cnt % 16];

  i2cs_reg_slave #(.TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .sda_pull_o(sda_pull), .evq_data_i(evq_data), .evq_pop_o(evq_pop),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (wr_valid) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
    if (evq_pop) pop_cnt++;
  end

  function automatic logic [7:0] nxt(logic [7:0] p);
    if (p == 0) return 0;
    if (p == 6) return 0;
    if (p < 6)  return p + 1;
    return p;
  endfunction
  function automatic logic [6:0] my_addr(logic [1:0] s);
    return 7'h38 | {4'd0, s, 1'b0};
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic i2c_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask
  task automatic xbit(input logic b, output logic r);
    sda_m = b; tick(Q); scl_m = 1; tick(Q); r = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(d[i], r);
    xbit(1'b1, r);
    ack = !r;
  endtask
  task automatic rbyte(input bit mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin xbit(1'b1, r); d[i] = r; end
    xbit(!mack, r);
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] p, int popidx);
    if (p == 0) return evq_mem[popidx % 16];
    if (p < 7)  return exp_reg[p];
    return 8'h00;
  endfunction

  // write: pointer byte then n data bytes (R2, R3, R4, R11, R12)
  task automatic do_write(logic [7:0] p, int n, bit stop_end);
    bit ack; logic [7:0] d; int w0;
    i2c_start();
    wbyte({my_addr(strap), 1'b0}, ack); chk(ack, "R1 addr ack", ack, 1);
    wbyte(p, ack); chk(ack, "R12 ptr ack", ack, 1);
    exp_ptr = p;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      w0 = wr_cnt;
      wbyte(d, ack); chk(ack, "R12 data ack", ack, 1);
      if (exp_ptr >= 1 && exp_ptr <= 6) begin
        chk(wr_cnt == w0 + 1 && last_wa == exp_ptr[2:0] && last_wd == d,
            "R3 write port", {last_wa, last_wd}, {exp_ptr[2:0], d});
        exp_reg[exp_ptr] = d;
      end else begin
        chk(wr_cnt == w0, "R11 dropped write", wr_cnt - w0, 0);
      end
      exp_ptr = nxt(exp_ptr);
    end
    if (stop_end) i2c_stop();
  endtask

  // read n bytes from current pointer (R4, R6, R7, R9)
  task automatic do_read(int n);
    bit ack; logic [7:0] d, e;
    i2c_start();
    wbyte({my_addr(strap), 1'b1}, ack); chk(ack, "R1 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      e = exp_rd(exp_ptr, exp_pop);
      rbyte(i < n - 1, d);
      chk(d == e, "R4 read data at pointer", d, e);
      if (exp_ptr == 0) exp_pop++;
      exp_ptr = nxt(exp_ptr);
    end
    tick(Q);
    chk(sda_pull == 0, "R7 released after NACK", sda_pull, 0);
    chk(pop_cnt == exp_pop, "R9 pop count", pop_cnt, exp_pop);
    i2c_stop();
  endtask

  task automatic bad_addr();
    bit ack; logic [6:0] a; int w0;
    do a = 7'($urandom); while (a == my_addr(strap));
    w0 = wr_cnt;
    i2c_start();
    wbyte({a, 1'b0}, ack); chk(!ack, "R1 foreign address ignored", ack, 0);
    wbyte(8'h02, ack); chk(!ack, "R1 foreign byte ignored", ack, 0);
    i2c_stop();
    chk(wr_cnt == w0, "R1 no write on foreign address", wr_cnt - w0, 0);
  endtask

  // hold SCL low during the address acknowledge (R10)
  task automatic hold_test(bit tmo_on);
    logic r; bit ack; int w0;
    i2c_start();
    for (int i = 7; i >= 0; i--) xbit(my_addr(strap)[i > 0 ? i - 1 : 0] & (i > 0) , r);
    tick(TMO + 40);
    chk(sda_pull == !tmo_on, "R10 line state after long low", sda_pull, !tmo_on);
    xbit(1'b1, r);
    chk((!r) == !tmo_on, "R10 ack after hold", !r, !tmo_on);
    w0 = wr_cnt;
    wbyte(8'h05, ack);
    chk(ack == !tmo_on, "R10 bus ignored until START", ack, !tmo_on);
    if (!tmo_on) exp_ptr = 8'h05;
    i2c_stop();
    chk(wr_cnt == w0, "R10 no write", wr_cnt - w0, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) evq_mem[i] = 8'($urandom);
    exp_reg[0] = 8'h00; exp_reg[1] = 8'h0A; exp_reg[2] = 8'hFF; exp_reg[3] = 8'h00;
    exp_reg[4] = 8'hFE; exp_reg[5] = 8'h00; exp_reg[6] = 8'h07;
    tick(5); rst_n = 1; tick(5);
    chk(sda_pull == 0 && evq_pop == 0 && wr_valid == 0, "R5 reset outputs", {sda_pull, evq_pop, wr_valid}, 0);

    // R5 reset values, wrap 6 -> 0 (R4), queue read (R9)
    do_write(8'd1, 0, 1'b1);
    chk(wr_cnt == 0, "R2 pointer-only write", wr_cnt, 0);
    do_read(8);
    chk(exp_ptr == 0, "R4 parked on index 0", exp_ptr, 0);
    // R11 writes to read-only index, pointer stays on 0
    do_write(8'd0, 2, 1'b1);
    do_read(2);
    // R8 repeated START keeps pointer: write index 3, then restart into read
    do_write(8'd3, 1, 1'b0);
    do_read(3);
    // index 7 kept (R4) and reads zero
    do_write(8'd7, 1, 1'b1);
    do_read(2);
    // R1 per strap code
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s); tick(2);
      do_write(8'd2, 1, 1'b1);
      bad_addr();
    end
    // R10 watchdog on, then off
    strap = 2'd1; tick(2);
    hold_test(1'b1);
    do_write(8'd1, 0, 1'b1);
    exp_reg[1] = 8'h0B;
    begin bit ack; i2c_start(); wbyte({my_addr(strap), 1'b0}, ack); wbyte(8'd1, ack);
          wbyte(8'h0B, ack); i2c_stop(); exp_ptr = 8'd2; end
    hold_test(1'b0);
    // random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      strap = 2'($urandom); tick(2);
      op = $urandom % 4;
      case (op)
        0: do_write(8'($urandom % 8), $urandom % 4, 1'b1);
        1: do_read(1 + $urandom % 4);
        2: begin do_write(8'($urandom % 8), $urandom % 2, 1'b0); do_read(1 + $urandom % 4); end
        default: bad_addr();
      endcase
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
    end
  end
endmodule